// File: doc/BRIEF.md
# Chainable first-word-fall-through FIFO stage

This block is a dual-clock FIFO stage that shows the oldest stored word at its output without any read strobe. Identical stages connect in series with no glue logic, and the chain gives a deeper queue. The top module is a parameterised chain of such stages. It exposes only the write side of the first stage and the read side of the last stage. All inner boundaries run on one transfer clock. The read clocks must run freely for words to advance through the chain.

Both stream handshakes are active-low valid/ready pairs. On the write side, the producer drives `wr_en_n` as its valid. `in_rdy_n` low means a free location exists. A word is taken on a `wr_clk` edge where both are low. On the read side, `out_vld_n` low means `rd_data` holds a valid word. The consumer drives `rd_en_n` low as its ready, and the word is consumed on a `rd_clk` edge where both are low.

Back-pressure works in both directions. A write attempt while `in_rdy_n` is high is dropped. While the consumer holds `rd_en_n` high, the output word and its valid stay put. Inside the chain, a stage's output-valid drives the next stage's write enable, and the next stage's input-ready drives this stage's read enable. Each stage stores `2**ADDR_W` words in memory plus one word in its output register. Its pointers cross clocks as Gray codes through two-flop synchronisers.

Top module: `fwft_chain`

## Requirements
- R1: An active-low `rst_n` empties every stage asynchronously. While it is low, and after it is released, `out_vld_n` is 1 and `in_rdy_n` is 0.
- R2: The first word written into an empty chain appears on `rd_data`, with `out_vld_n` low, without any read strobe.
- R3: While `out_vld_n` is low and `rd_en_n` is high, `rd_data` and `out_vld_n` hold their values. The output changes only on a `rd_clk` edge where both are low. After such an edge the next stored word is shown at once if one is available, and otherwise `out_vld_n` rises.
- R4: A read strobe (`rd_en_n` low) while `out_vld_n` is high has no effect on the stored contents.
- R5: A write while `in_rdy_n` is high is dropped. `in_rdy_n` rises only after an edge where a write was accepted.
- R6: Words leave the chain intact and in the order they were accepted.
- R7: The chain holds exactly `STAGES*(2**ADDR_W+1)` words before `in_rdy_n` goes high.
- R8: With one common clock and an empty chain, suppose a word is written at edge 0. Then `out_vld_n` is 1 after edge `4*(STAGES-1)+2` and 0 after edge `4*(STAGES-1)+3`.
- R9: With one common clock and a full chain, suppose the last stage is read at edge 0. Then `in_rdy_n` is 1 after edge `3*(STAGES-1)+1` and 0 after edge `3*(STAGES-1)+2`.
- R10: Consider words written back to back into an empty chain while the consumer keeps `rd_en_n` low. Word i appears after edge `4*(STAGES-1)+3+i`, so only the first word pays the fill latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock of the first stage |
| xfer_clk | input | 1 | Clock shared by all inner stage boundaries |
| rd_clk | input | 1 | Read clock of the last stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | DATA_W | Write data |
| wr_en_n | input | 1 | Active-low write enable (producer valid) |
| in_rdy_n | output | 1 | Active-low input ready (free location present) |
| rd_data | output | DATA_W | Oldest stored word |
| rd_en_n | input | 1 | Active-low read enable (consumer ready) |
| out_vld_n | output | 1 | Active-low output valid |

## Verification
Some rules are checked on every cycle. On the read side, the output word and its valid hold while the consumer stalls, and valid drops only after a read. On the write side, input-ready rises only after an accepted write. The bench scenarios show the rest. These are the exact ripple-down and bubble-up edge counts, the full-rate streaming after the first word, and the total capacity. The scenarios also show FIFO ordering and data integrity across the chain, and that strobes against a full or empty chain are dropped.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/fwft_sync.sv
module fwft_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fwft_wr_side.sv
module fwft_wr_side
  import fwft_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wen_n,
  input  logic [ADDR_W:0] rgray_s,
  output logic            we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0] wgray,
  output logic            full_n_rdy
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH = PW'(2 ** ADDR_W);

  logic [PW-1:0] wbin;
  logic [PW-1:0] wbin_nx;
  logic [PW-1:0] rbin_s;
  logic [31:0]   rbin_wide;
  logic [31:0]   gray_wide;
  logic          full;

  always_comb begin
    rbin_wide = gray_to_bin(32'(rgray_s));
    rbin_s    = rbin_wide[PW-1:0];
    full      = (wbin - rbin_s) == DEPTH;
    we        = !wen_n && !full;
    wbin_nx   = wbin + PW'(1);
    gray_wide = bin_to_gray(32'(wbin_nx));
  end

  assign waddr      = wbin[ADDR_W-1:0];
  assign full_n_rdy = full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= gray_wide[PW-1:0];
    end
  end
endmodule

// File: rtl/fwft_rd_side.sv
module fwft_rd_side
  import fwft_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_n,
  input  logic [ADDR_W:0]   wgray_s,
  output logic              load,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              vld_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] rbin;
  logic [PW-1:0] rbin_nx;
  logic [PW-1:0] wbin_s;
  logic [31:0]   wbin_wide;
  logic [31:0]   gray_wide;
  logic          avail;
  logic          pop;

  always_comb begin
    wbin_wide = gray_to_bin(32'(wgray_s));
    wbin_s    = wbin_wide[PW-1:0];
    avail     = wbin_s != rbin;
    pop       = !vld_n && !ren_n;
    load      = avail && (vld_n || pop);
    rbin_nx   = rbin + PW'(1);
    gray_wide = bin_to_gray(32'(rbin_nx));
  end

  assign raddr = rbin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      vld_n <= 1'b1;
    end else if (load) begin
      rbin  <= rbin_nx;
      rgray <= gray_wide[PW-1:0];
      vld_n <= 1'b0;
    end else if (pop) begin
      vld_n <= 1'b1;
    end
  end
endmodule

// File: rtl/fwft_stage.sv
module fwft_stage #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              wen_n,
  output logic              ir_n,
  output logic [DATA_W-1:0] dout,
  input  logic              ren_n,
  output logic              or_n
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              we;
  logic              load;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [ADDR_W:0]   wgray;
  logic [ADDR_W:0]   rgray;
  logic [ADDR_W:0]   wgray_s;
  logic [ADDR_W:0]   rgray_s;

  fwft_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wclk), .rst_n(rst_n), .wen_n(wen_n), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wgray(wgray), .full_n_rdy(ir_n)
  );

  fwft_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rclk), .rst_n(rst_n), .ren_n(ren_n), .wgray_s(wgray_s),
    .load(load), .raddr(raddr), .rgray(rgray), .vld_n(or_n)
  );

  fwft_sync #(.WIDTH(ADDR_W + 1)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  fwft_sync #(.WIDTH(ADDR_W + 1)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= din;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else if (load) dout <= mem[raddr];
  end
endmodule

// File: rtl/fwft_chain.sv
module fwft_chain #(
  parameter int STAGES = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              xfer_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en_n,
  output logic              in_rdy_n,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_en_n,
  output logic              out_vld_n
);
  localparam int LAST = STAGES - 1;

  logic [DATA_W-1:0] q_lnk  [STAGES];
  logic              or_lnk [STAGES];
  logic              ir_lnk [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic              wc;
    logic              rc;
    logic [DATA_W-1:0] d_in;
    logic              w_n;
    logic              r_n;

    if (k == 0) begin : g_head
      assign wc   = wr_clk;
      assign d_in = wr_data;
      assign w_n  = wr_en_n;
    end else begin : g_inner_w
      assign wc   = xfer_clk;
      assign d_in = q_lnk[k-1];
      assign w_n  = or_lnk[k-1];
    end

    if (k == LAST) begin : g_tail
      assign rc  = rd_clk;
      assign r_n = rd_en_n;
    end else begin : g_inner_r
      assign rc  = xfer_clk;
      assign r_n = ir_lnk[k+1];
    end

    fwft_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stage (
      .wclk(wc), .rclk(rc), .rst_n(rst_n),
      .din(d_in), .wen_n(w_n), .ir_n(ir_lnk[k]),
      .dout(q_lnk[k]), .ren_n(r_n), .or_n(or_lnk[k])
    );
  end

  assign in_rdy_n  = ir_lnk[0];
  assign rd_data   = q_lnk[LAST];
  assign out_vld_n = or_lnk[LAST];
endmodule

// File: rtl/fwft_chain_chk.sv
module fwft_chain_chk #(
  parameter int DATA_W = 16
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              wr_en_n,
  input logic              in_rdy_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_en_n,
  input logic              out_vld_n
);
  assert_valid_hold_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!out_vld_n && rd_en_n) |=> !out_vld_n);

  assert_data_hold_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!out_vld_n && rd_en_n) |=> $stable(rd_data));

  assert_valid_drop_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $rose(out_vld_n) |-> $past(!rd_en_n));

  assert_ready_rise_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $rose(in_rdy_n) |-> $past(!wr_en_n && !in_rdy_n));
endmodule

bind fwft_chain fwft_chain_chk #(.DATA_W(DATA_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
  .in_rdy_n(in_rdy_n), .rd_data(rd_data), .rd_en_n(rd_en_n),
  .out_vld_n(out_vld_n)
);

// File: tb/fwft_chain_bench.sv
module fwft_chain_bench;
  localparam int N     = 3;
  localparam int AW    = 3;
  localparam int W     = 16;
  localparam int L_RIP = 4 * (N - 1) + 3;
  localparam int L_BUB = 3 * (N - 1) + 2;
  localparam int CAP   = N * (2 ** AW + 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic         wen_n = 1'b1;
  logic         ren_n = 1'b1;
  logic         ir_n;
  logic         or_n;
  logic [W-1:0] dout;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fwft_chain #(.STAGES(N), .DATA_W(W), .ADDR_W(AW)) u_fwft_chain (
    .wr_clk(clk), .xfer_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wr_data(din), .wr_en_n(wen_n), .in_rdy_n(ir_n),
    .rd_data(dout), .rd_en_n(ren_n), .out_vld_n(or_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    wen_n = 1'b1; ren_n = 1'b1;
    #3 rst_n = 1'b0;
    #1;
    chk("R1 out_vld_n in reset", 32'(or_n), 1);
    chk("R1 in_rdy_n in reset", 32'(ir_n), 0);
    step();
    step();
    rst_n = 1'b1;
    step();
    chk("R1 out_vld_n after reset", 32'(or_n), 1);
    chk("R1 in_rdy_n after reset", 32'(ir_n), 0);
  endtask

  task automatic t_empty_read();
    ren_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R4 strobe on empty keeps out_vld_n", 32'(or_n), 1);
    end
    ren_n = 1'b1;
  endtask

  task automatic t_ripple(input logic [W-1:0] w);
    din = w; wen_n = 1'b0;
    step();
    wen_n = 1'b1;
    for (int k = 1; k <= L_RIP; k++) begin
      step();
      if (k == L_RIP - 1) chk("R8 out_vld_n one edge early", 32'(or_n), 1);
    end
    chk("R8 out_vld_n at ripple latency", 32'(or_n), 0);
    chk("R2 word falls through", 32'(dout), 32'(w));
    step();
    chk("R3 no read keeps word", 32'(dout), 32'(w));
    ren_n = 1'b0;
    step();
    ren_n = 1'b1;
    chk("R3 last word read empties", 32'(or_n), 1);
  endtask

  task automatic t_stream();
    ren_n = 1'b0;
    din = 16'h5000; wen_n = 1'b0;
    for (int k = 0; k <= L_RIP + 7; k++) begin
      step();
      if (k + 1 < 6) din = 16'(16'h5000 + k + 1);
      else wen_n = 1'b1;
      if (k == L_RIP - 1) chk("R10 not yet valid", 32'(or_n), 1);
      if (k >= L_RIP && k < L_RIP + 6) begin
        chk("R10 streaming valid", 32'(or_n), 0);
        chk("R10 streaming word", 32'(dout), 32'(16'h5000 + k - L_RIP));
      end
      if (k == L_RIP + 6) chk("R10 empty after burst", 32'(or_n), 1);
    end
    ren_n = 1'b1;
  endtask

  task automatic t_fill();
    int acc = 0;
    int ign = 0;
    ren_n = 1'b1;
    for (int i = 0; i < 150; i++) begin
      wen_n = 1'b0;
      if (ir_n == 1'b0) begin
        din = 16'(100 + acc);
        acc++;
      end else begin
        din = 16'hDEAD;
        ign++;
      end
      step();
    end
    wen_n = 1'b1;
    for (int i = 0; i < 20; i++) step();
    chk("R7 capacity", acc, CAP);
    chk("R5 writes dropped while not ready", 32'(ign > 0), 1);
    chk("R7 in_rdy_n high when full", 32'(ir_n), 1);
    chk("R6 head word", 32'(dout), 100);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 hold valid", 32'(or_n), 0);
      chk("R3 hold data", 32'(dout), 100);
    end
  endtask

  task automatic t_bubble();
    chk("R9 full before read", 32'(ir_n), 1);
    ren_n = 1'b0;
    step();
    ren_n = 1'b1;
    chk("R3 advance to next word", 32'(dout), 101);
    for (int k = 1; k <= L_BUB; k++) begin
      step();
      if (k == L_BUB - 1) chk("R9 in_rdy_n one edge early", 32'(ir_n), 1);
    end
    chk("R9 in_rdy_n at bubble latency", 32'(ir_n), 0);
  endtask

  task automatic t_drain();
    int got = 0;
    ren_n = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (or_n == 1'b0) begin
        chk("R6 order and data", 32'(dout), 32'(101 + got));
        got++;
      end
      step();
    end
    ren_n = 1'b1;
    chk("R6 word count after drain", got, CAP - 1);
    chk("R4 empty after drain", 32'(or_n), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_empty_read();
    t_ripple(16'hA5C3);
    t_stream();
    t_reset();
    t_fill();
    t_hold();
    t_bubble();
    t_drain();
    din = 16'h1234; wen_n = 1'b0;
    step();
    wen_n = 1'b1;
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule